// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host-visible buffers under the control of a ring of receive descriptors. The descriptors live in an internal memory. Host software reads and writes them, together with a kick register, through a simple single-cycle register port. Each descriptor owns one fixed-size buffer slot. The engine takes frames from a byte stream that carries start, end and error markers. It writes each accepted byte into the slot of the current descriptor through a byte-wide buffer write port.

When a frame ends, the engine writes a completion status into the descriptor. This status is the byte count, which includes the trailing 4-byte CRC, plus an error flag in a separate high word. Writing the status clears the hardware-ownership bit, and the engine then moves to the next descriptor in ring order. Software hands a descriptor back by clearing its high word and setting its ownership bit. It moves the kick index to say how far the ring is available. A frame that finds no usable descriptor is discarded and counted.

Top module: `rxring_top`

## Requirements
- R1: After a synchronous reset, `buf_we` and `rx_done` are low, `drop_count` is 0, the kick register reads 0 and the engine starts at descriptor 0.
- R2: Host address map: when bit 6 of `host_addr` is 0, bits 5:1 select a descriptor and bit 0 selects the word (0 = command word, 1 = high status word). When bit 6 is 1, the 6-bit kick register is selected. A write takes effect at the clock edge. `host_rdata` shows the selected word one cycle after the address is presented. An ownership change affects only frames whose start beat comes at least two cycles after the write.
- R3: A start beat is accepted when bit 31 of the current descriptor's command word is 1 and the descriptor index differs from the kick value. Each accepted byte appears on `buf_we`/`buf_data` one cycle after its beat. `buf_addr` = {descriptor index, byte offset}, and the offset counts up from 0.
- R4: On the end beat of an accepted frame, the command word becomes: bit 31 = 0, bits 30:16 = number of bytes received (the CRC bytes included), bits 15:0 = 0. The high word becomes 0 for a clean frame.
- R5: If `rx_err` is high on any beat of an accepted frame, bit 30 of the high word is set at completion and every other bit of that word is 0.
- R6: For a frame longer than 2048 bytes, only the first 2048 bytes are written and the rest are discarded. The length field is 2048 and bit 30 of the high word is set. A frame of exactly 2048 bytes completes cleanly.
- R7: A start beat that is not accepted causes no buffer write and no write-back to any descriptor. The frame's remaining beats up to its end beat are ignored. `drop_count` rises by one, saturating, one cycle after the start beat, and the current index does not advance.
- R8: The current index advances by one after each completed frame and wraps from 31 to 0.
- R9: `rx_done` is high for exactly the cycle after the end beat of each accepted frame, and at no other time.
- R10: A kick value of 32 makes every owned descriptor usable. A kick value k below 32 blocks descriptor k even if it is owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 7 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the address |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Frame error marker on this beat |
| rx_data | input | 8 | Receive byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 16 | Buffer byte address {index, offset} |
| buf_data | output | 8 | Buffer byte |
| rx_done | output | 1 | One-cycle frame completion pulse |
| drop_count | output | 16 | Saturating count of discarded frames |

## Verification
Each byte write is due one cycle after its beat. The descriptor write-back and the `rx_done` pulse are due on the edge that samples the end beat, so a host read issued from the next cycle on returns the new status. `drop_count` moves one cycle after a rejected start beat. A behavioural reference model in the bench advances on each rising edge from the same inputs the design sees. The bench compares the outputs with the model's expectations at the following falling edge, which is exactly the due cycle. Host read-backs sample `host_rdata` on the falling edge after the edge that captured the address. Every ownership or kick change is made at least three cycles before the next start beat.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_POS = 31;
  localparam int ERR_POS = 30;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 15;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RECV = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
#(
  parameter int NUM_DESC = 32,
  parameter int IDX_W    = 5,
  parameter int HA_W     = 7,
  parameter int KICK_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_we,
  input  logic [HA_W-1:0]              host_addr,
  input  logic [WORD_W-1:0]            host_wdata,
  output logic [WORD_W-1:0]            host_rdata,
  input  logic                         eng_we,
  input  logic [IDX_W-1:0]             eng_idx,
  input  logic [1:0][WORD_W-1:0]       eng_word,
  input  logic [IDX_W-1:0]             eng_rd_idx,
  output logic                         own_q,
  output logic [KICK_W-1:0]            kick
);
  logic             host_kick;
  logic [IDX_W-1:0] host_idx;
  logic             host_sel;
  logic             sel_q;
  logic             kick_sel_q;
  logic [KICK_W-1:0] kick_rd_q;

  assign host_kick = host_addr[HA_W-1];
  assign host_idx  = host_addr[IDX_W:1];
  assign host_sel  = host_addr[0];

  // One inferred memory per descriptor word: host port and engine port.
  for (genvar w = 0; w < 2; w++) begin : g_word
    logic [WORD_W-1:0] mem [NUM_DESC];
    logic [WORD_W-1:0] hrd;

    always_ff @(posedge clk) begin
      if (eng_we) mem[eng_idx] <= eng_word[w];
      if (host_we && !host_kick && (host_sel == 1'(w))) mem[host_idx] <= host_wdata;
      hrd <= mem[host_idx];
    end

    if (w == 0) begin : g_own
      always_ff @(posedge clk) begin
        if (rst) own_q <= 1'b0;
        else     own_q <= mem[eng_rd_idx][OWN_POS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kick       <= '0;
      sel_q      <= 1'b0;
      kick_sel_q <= 1'b0;
      kick_rd_q  <= '0;
    end else begin
      if (host_we && host_kick) kick <= host_wdata[KICK_W-1:0];
      sel_q      <= host_sel;
      kick_sel_q <= host_kick;
      kick_rd_q  <= kick;
    end
  end

  assign host_rdata = kick_sel_q ? WORD_W'(kick_rd_q)
                    : (sel_q ? g_word[1].hrd : g_word[0].hrd);
endmodule

// File: rtl/rxring_fsm.sv
module rxring_fsm
  import rxring_pkg::*;
#(
  parameter int NUM_DESC  = 32,
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 5,
  parameter int OFF_W     = 11,
  parameter int KICK_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_valid,
  input  logic                   rx_sof,
  input  logic                   rx_eof,
  input  logic                   rx_err,
  input  logic [7:0]             rx_data,
  input  logic                   own,
  input  logic [KICK_W-1:0]      kick,
  output logic                   buf_we,
  output logic [IDX_W+OFF_W-1:0] buf_addr,
  output logic [7:0]             buf_data,
  output logic                   rx_done,
  output logic [CNT_W-1:0]       drop_count,
  output logic                   wb_en,
  output logic [IDX_W-1:0]       wb_idx,
  output logic [1:0][WORD_W-1:0] wb_word,
  output logic [IDX_W-1:0]       rd_idx
);
  localparam int CW = OFF_W + 1;
  localparam logic [CW-1:0]    BUF_CAP  = CW'(BUF_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

  rx_state_e        st;
  logic [IDX_W-1:0] cur_idx, next_idx;
  logic [CW-1:0]    cnt_q, base_cnt, new_cnt;
  logic             err_q, trunc_q, new_err, new_trunc;
  logic             accept, reject, take, room, store, finish;
  logic [LEN_W-1:0] len_f;

  always_comb begin
    accept    = (st == RX_IDLE) && rx_valid && rx_sof && own &&
                ({1'b0, cur_idx} != kick);
    reject    = (st == RX_IDLE) && rx_valid && rx_sof && !accept;
    take      = accept || ((st == RX_RECV) && rx_valid);
    base_cnt  = accept ? '0 : cnt_q;
    room      = base_cnt < BUF_CAP;
    store     = take && room;
    new_cnt   = base_cnt + CW'(store);
    new_err   = (accept ? 1'b0 : err_q) | rx_err;
    new_trunc = (accept ? 1'b0 : trunc_q) | (take && !room);
    finish    = take && rx_eof;
    next_idx  = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
    rd_idx    = finish ? next_idx : cur_idx;
    len_f     = LEN_W'(new_cnt);
    wb_en     = finish;
    wb_idx    = cur_idx;
    wb_word   = '0;
    wb_word[0][LEN_LSB +: LEN_W] = len_f;
    wb_word[1][ERR_POS]          = new_err | new_trunc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      cur_idx    <= '0;
      cnt_q      <= '0;
      err_q      <= 1'b0;
      trunc_q    <= 1'b0;
      buf_we     <= 1'b0;
      buf_addr   <= '0;
      buf_data   <= '0;
      rx_done    <= 1'b0;
      drop_count <= '0;
    end else begin
      buf_we  <= store;
      rx_done <= finish;
      if (store) begin
        buf_addr <= {cur_idx, base_cnt[OFF_W-1:0]};
        buf_data <= rx_data;
      end
      if (reject && (drop_count != '1)) drop_count <= drop_count + 1'b1;
      if (take) begin
        cnt_q   <= new_cnt;
        err_q   <= new_err;
        trunc_q <= new_trunc;
      end
      if (finish) cur_idx <= next_idx;
      case (st)
        RX_IDLE: begin
          if (accept)      st <= rx_eof ? RX_IDLE : RX_RECV;
          else if (reject) st <= rx_eof ? RX_IDLE : RX_DROP;
        end
        RX_RECV: if (rx_valid && rx_eof) st <= RX_IDLE;
        RX_DROP: if (rx_valid && rx_eof) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter int NUM_DESC  = 32,
  parameter int BUF_BYTES = 2048,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_DESC),
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int HA_W     = IDX_W + 2,
  localparam int KICK_W   = IDX_W + 1,
  localparam int BA_W     = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  input  logic [7:0]        rx_data,
  output logic              buf_we,
  output logic [BA_W-1:0]   buf_addr,
  output logic [7:0]        buf_data,
  output logic              rx_done,
  output logic [CNT_W-1:0]  drop_count
);
  logic                   own_q;
  logic [KICK_W-1:0]      kick;
  logic                   wb_en;
  logic [IDX_W-1:0]       wb_idx;
  logic [1:0][WORD_W-1:0] wb_word;
  logic [IDX_W-1:0]       rd_idx;

  rxring_regs #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .HA_W(HA_W), .KICK_W(KICK_W)
  ) regs_i (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_we(wb_en), .eng_idx(wb_idx), .eng_word(wb_word),
    .eng_rd_idx(rd_idx), .own_q(own_q), .kick(kick)
  );

  rxring_fsm #(
    .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .KICK_W(KICK_W)
  ) fsm_i (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_err(rx_err), .rx_data(rx_data),
    .own(own_q), .kick(kick),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .rx_done(rx_done), .drop_count(drop_count),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_word(wb_word), .rd_idx(rd_idx)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int CNT_W = 16,
  parameter int BA_W  = 16,
  parameter int OFF_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_eof,
  input logic             buf_we,
  input logic [BA_W-1:0]  buf_addr,
  input logic             rx_done,
  input logic [CNT_W-1:0] drop_count
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!buf_we && !rx_done && drop_count == '0));

  // R9
  done_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(rx_valid && rx_eof));

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

  // R7
  drop_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> !rx_done);

  // R3
  buf_after_beat_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(rx_valid));

  // R3
  buf_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we) && (buf_addr[OFF_W-1:0] != '0))
      |-> (buf_addr == $past(buf_addr) + 1'b1));
endmodule

bind rxring_top rxring_chk #(.CNT_W(CNT_W), .BA_W(BA_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .buf_we(buf_we), .buf_addr(buf_addr), .rx_done(rx_done),
  .drop_count(drop_count)
);

// File: tb/rxring_top_tb_top.sv
`timescale 1ns/100ps
module rxring_top_tb_top;
  localparam int ND = 32;
  localparam int BB = 2048;
  localparam int KICK_ADDR = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        buf_we;
  logic [15:0] buf_addr;
  logic [7:0]  buf_data;
  logic        rx_done;
  logic [15:0] drop_count;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  rxring_top dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_data(rx_data), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_data(buf_data), .rx_done(rx_done), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Behavioural reference model
  logic [31:0] m_cmd [ND];
  logic [31:0] m_hi  [ND];
  int   m_kick, m_idx, m_st, m_cnt, m_drop, e_addr;
  bit   m_err, m_trunc, e_we, e_done;
  logic [7:0] e_data;

  always @(posedge clk) begin
    if (rst) begin
      m_kick = 0; m_idx = 0; m_st = 0; m_drop = 0;
      e_we = 0; e_done = 0;
    end else begin
      e_we = 0; e_done = 0;
      if (host_we) begin
        if (host_addr[6])      m_kick = int'(host_wdata[5:0]);
        else if (host_addr[0]) m_hi[host_addr[5:1]] = host_wdata;
        else                   m_cmd[host_addr[5:1]] = host_wdata;
      end
      if (rx_valid) begin
        if (m_st == 0 && rx_sof) begin
          if (m_cmd[m_idx][31] && m_idx != m_kick) begin
            m_st = 1; m_cnt = 0; m_err = 0; m_trunc = 0;
          end else begin
            if (m_drop < 65535) m_drop++;
            if (!rx_eof) m_st = 2;
          end
        end else if (m_st == 2) begin
          if (rx_eof) m_st = 0;
        end
        if (m_st == 1) begin
          if (m_cnt < BB) begin
            e_we = 1; e_addr = m_idx * BB + m_cnt; e_data = rx_data; m_cnt++;
          end else m_trunc = 1;
          if (rx_err) m_err = 1;
          if (rx_eof) begin
            m_cmd[m_idx] = 32'(m_cnt) << 16;
            m_hi[m_idx]  = (m_err || m_trunc) ? 32'h4000_0000 : 32'h0;
            m_idx = (m_idx + 1) % ND;
            m_st = 0;
            e_done = 1;
          end
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(buf_we === e_we &&
            (!e_we || (buf_addr === e_addr[15:0] && buf_data === e_data)),
            "R3 buffer write", {7'd0, buf_we, buf_addr, buf_data},
            {7'd0, e_we, e_addr[15:0], e_data});
      check(rx_done === e_done, "R9 done pulse", 32'(rx_done), 32'(e_done));
      check(drop_count === m_drop[15:0], "R7 drop count",
            32'(drop_count), 32'(m_drop));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic hwrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    host_we = 1'b1; host_addr = addr[6:0]; host_wdata = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_addr = addr[6:0];
    @(posedge clk);
    @(negedge clk);
    check(host_rdata === exp, tag, host_rdata, exp);
  endtask

  task automatic send_frame(input int len, input int errpos, input int seed,
                            input bit gaps, input int lead, input bit tail);
    repeat (lead) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        rx_valid = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = (i == len - 1);
      rx_err   = (i == errpos);
      rx_data  = 8'(seed + i);
    end
    if (tail) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(buf_we === 1'b0 && rx_done === 1'b0 && drop_count === 16'd0,
          "R1 reset outputs", {buf_we, rx_done, drop_count}, 32'd0);
    hread(KICK_ADDR, 32'd0, "R1 kick after reset");

    // R2: initialise ring through the host port
    for (int d = 0; d < ND; d++) begin
      hwrite(2 * d, 32'h8000_0000);
      hwrite(2 * d + 1, 32'h0);
    end
    hwrite(KICK_ADDR, 32'd32);
    hread(10, 32'h8000_0000, "R2 command readback");
    hread(KICK_ADDR, 32'd32, "R2 kick readback");

    // R4: clean frame into descriptor 0
    send_frame(64, -1, 16, 1'b0, 3, 1'b1);
    hread(0, 32'd64 << 16, "R4 length word");
    hread(1, 32'h0, "R4 clean status");

    // R5: error mid-frame with idle gaps, descriptor 1
    send_frame(20, 7, 80, 1'b1, 3, 1'b1);
    hread(2, 32'd20 << 16, "R5 length word");
    hread(3, 32'h4000_0000, "R5 error flag");

    // R4: single-byte frame, descriptor 2
    send_frame(1, -1, 200, 1'b0, 3, 1'b1);
    hread(4, 32'd1 << 16, "R4 single byte");

    // R6: oversize frame, descriptor 3; exact-size frame, descriptor 4
    send_frame(2050, -1, 3, 1'b0, 3, 1'b1);
    hread(6, 32'd2048 << 16, "R6 truncated length");
    hread(7, 32'h4000_0000, "R6 truncation flag");
    send_frame(2048, -1, 9, 1'b0, 3, 1'b1);
    hread(8, 32'd2048 << 16, "R6 exact length");
    hread(9, 32'h0, "R6 exact clean");

    // R7: descriptor 5 not owned
    hwrite(10, 32'h0);
    send_frame(30, -1, 40, 1'b0, 3, 1'b1);
    @(negedge clk);
    check(drop_count === 16'd1, "R7 drop counted", 32'(drop_count), 32'd1);
    hread(10, 32'h0, "R7 no write-back");
    hwrite(10, 32'h8000_0000);
    send_frame(12, -1, 50, 1'b0, 3, 1'b1);
    hread(10, 32'd12 << 16, "R7 index held");

    // R10: kick blocks descriptor 7
    hwrite(KICK_ADDR, 32'd7);
    send_frame(9, -1, 60, 1'b0, 3, 1'b1);
    hread(12, 32'd9 << 16, "R10 below kick");
    send_frame(9, -1, 70, 1'b0, 3, 1'b1);
    @(negedge clk);
    check(drop_count === 16'd2, "R10 blocked at kick", 32'(drop_count), 32'd2);
    hread(14, 32'h8000_0000, "R10 descriptor untouched");
    hwrite(KICK_ADDR, 32'd32);

    // R8: back-to-back frames fill 7..31, then wrap to 0
    for (int k = 0; k < 25; k++)
      send_frame(5 + k, -1, k, 1'b0, (k == 0) ? 3 : 0, k == 24);
    hread(62, 32'(29) << 16, "R8 last descriptor");
    hwrite(1, 32'h0);
    hwrite(0, 32'h8000_0000);
    send_frame(33, -1, 90, 1'b0, 3, 1'b1);
    hread(0, 32'd33 << 16, "R8 wrap to zero");
    hread(1, 32'h0, "R8 recycled status");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule